// File: doc/BRIEF.md
# Microprogram Sequencer with Memory Stall

This block steers a microcoded controller. It holds the micro-program counter (`upc`) and reads one control-store word for it in every cycle. Each word sets every control line at once: a line the microprogrammer leaves out is simply a 0 bit. All lines of a word act in the same cycle, in no order among themselves. Any ordering between actions has to be spread over successive words.

Four sequencing bits in each word choose the next address:

- **finish** returns to the shared fetch routine.
- **branch** tests one of the condition flags.
- **dispatch** jumps by instruction opcode once the fetch routine has run.
- **memory-wait** holds the counter until the memory reports completion.

These bits only choose which word runs next. The current word always completes in full. The datapath and the memory lie outside the block. The control store is a small ROM inside it, filled by a package function.

The fetch routine occupies addresses 0, 1 and 2. Instruction-specific routines start at address 3 or above.

Top module: `useq_top`

## Requirements
- R1: A synchronous `rst` high at a clock edge sets `upc` to 0, and `ctl_out` then shows word 0 (value 0x07).
- R2: `ctl_out` is the control field of the word at the current `upc` in the same cycle. The program is listed below as address: control value, then the sequencing bits:
  - Fetch routine: 0: 0x07; 1: 0x08, wait; 2: 0x10, dispatch.
  - Opcode 0 routine: 3: 0x21, finish.
  - Opcode 1 routine: 6: 0x42, wait; 7: 0x84, wait+finish.
  - Opcode 2 routine: 9: 0x11, branch on `flags[0]` to 12; 10: 0x22, finish; 12: 0x44, finish.
  - Opcode 3 routine: 13: 0x88, branch on `flags[1]` to 15; 14: 0x03, finish; 15: 0x0C, finish.
- R3: A word with no sequencing bit set advances `upc` by one at the next edge.
- R4: In a word with the wait bit set, `upc` holds while `mfc` is 0 and advances in the cycle that `mfc` is 1. `mfc` has no effect on a word without the wait bit.
- R5: A word with the finish bit loads `upc` with 0 at the next edge.
- R6: The dispatch word at address 2 loads `upc` from the opcode table (0→3, 1→6, 2→9, 3→13). The table is indexed by the `opcode` value present in that cycle only.
- R7: A branch word loads its target when the selected flag is 1, and otherwise increments. Only the flag that the word selects matters.
- R8: In a word that has both wait and finish set, the finish takes effect only at the edge where `mfc` is 1. Until then `upc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mfc | input | 1 | Memory function complete |
| flags | input | 2 | Condition flags tested by branch words |
| opcode | input | 2 | Instruction opcode used at dispatch |
| ctl_out | output | 8 | Datapath control lines of the current word |
| upc | output | 5 | Current micro-program counter |

## Verification
A wrong next-address choice shows at the ports one edge later: `upc` takes an unexpected value, and `ctl_out` carries the wrong control word in that same cycle. Every check therefore compares both ports in every cycle of a routine. A missing stall shows as the counter leaving a wait word while `mfc` is low. A wrongly timed finish shows as a premature return to 0. A mis-selected flag or opcode sends the run into a routine whose control values differ from the expected ones.

// File: rtl/useq_pkg.sv
package useq_pkg;
    parameter int UA_W   = 5;
    parameter int OPC_W  = 2;
    parameter int CTL_W  = 8;
    parameter int FLAG_N = 2;
    localparam int FSEL_W     = (FLAG_N > 1) ? $clog2(FLAG_N) : 1;
    localparam int DEPTH      = 1 << UA_W;
    localparam int FETCH_LAST = 2;

    typedef logic [UA_W-1:0]  uaddr_t;
    typedef logic [CTL_W-1:0] ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic              seq_end;
        logic              seq_if;
        logic              seq_wait;
        logic              seq_disp;
        logic [FSEL_W-1:0] fsel;
        uaddr_t            target;
    } uword_t;

    function automatic uword_t mk(input ctl_t c, input logic e, input logic b,
                                  input logic w, input logic d,
                                  input int fs, input int tg);
        uword_t r;
        r.ctl      = c;
        r.seq_end  = e;
        r.seq_if   = b;
        r.seq_wait = w;
        r.seq_disp = d;
        r.fsel     = FSEL_W'(fs);
        r.target   = uaddr_t'(tg);
        return r;
    endfunction

    function automatic uword_t store_word(input uaddr_t a);
        case (int'(a))
            0:       return mk(ctl_t'(8'h07), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
            1:       return mk(ctl_t'(8'h08), 1'b0, 1'b0, 1'b1, 1'b0, 0, 0);
            2:       return mk(ctl_t'(8'h10), 1'b0, 1'b0, 1'b0, 1'b1, 0, 0);
            3:       return mk(ctl_t'(8'h21), 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
            6:       return mk(ctl_t'(8'h42), 1'b0, 1'b0, 1'b1, 1'b0, 0, 0);
            7:       return mk(ctl_t'(8'h84), 1'b1, 1'b0, 1'b1, 1'b0, 0, 0);
            9:       return mk(ctl_t'(8'h11), 1'b0, 1'b1, 1'b0, 1'b0, 0, 12);
            10:      return mk(ctl_t'(8'h22), 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
            12:      return mk(ctl_t'(8'h44), 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
            13:      return mk(ctl_t'(8'h88), 1'b0, 1'b1, 1'b0, 1'b0, 1, 15);
            14:      return mk(ctl_t'(8'h03), 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
            15:      return mk(ctl_t'(8'h0C), 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
            default: return mk(ctl_t'(0),    1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
        endcase
    endfunction

    function automatic uaddr_t disp_entry(input int op);
        case (op)
            0:       return uaddr_t'(3);
            1:       return uaddr_t'(6);
            2:       return uaddr_t'(9);
            3:       return uaddr_t'(13);
            default: return uaddr_t'(0);
        endcase
    endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    uword_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = store_word(uaddr_t'(g));
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output uaddr_t           entry
);
    localparam int NOPC = 1 << OPC_W;
    uaddr_t table_q [NOPC];

    for (genvar g = 0; g < NOPC; g++) begin : g_tab
        assign table_q[g] = disp_entry(g);
    end

    assign entry = table_q[opcode];
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uaddr_t            cur,
    input  uword_t            w,
    input  logic              mfc,
    input  logic [FLAG_N-1:0] flags,
    input  uaddr_t            entry,
    output logic              stall,
    output uaddr_t            nxt
);
    logic taken;

    assign stall = w.seq_wait & ~mfc;
    assign taken = w.seq_if & flags[w.fsel];

    always_comb begin
        if (stall)           nxt = cur;
        else if (w.seq_end)  nxt = '0;
        else if (w.seq_disp) nxt = entry;
        else if (taken)      nxt = w.target;
        else                 nxt = uaddr_t'(cur + 1'b1);
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mfc,
    input  logic [FLAG_N-1:0] flags,
    input  logic [OPC_W-1:0]  opcode,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [UA_W-1:0]   upc
);
    uaddr_t upc_q, nxt, entry;
    uword_t w;
    logic   stall;

    useq_store    i_store (.addr(upc_q), .word(w));
    useq_dispatch i_disp  (.opcode(opcode), .entry(entry));
    useq_next     i_next  (.cur(upc_q), .w(w), .mfc(mfc), .flags(flags),
                           .entry(entry), .stall(stall), .nxt(nxt));

    always_ff @(posedge clk) begin
        if (rst) upc_q <= '0;
        else     upc_q <= nxt;
    end

    assign upc     = upc_q;
    assign ctl_out = w.ctl;

    assert_reset_zero_R1: assert property (@(posedge clk) rst |=> upc_q == '0);

    assert_plain_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!w.seq_wait && !w.seq_end && !w.seq_if && !w.seq_disp)
        |=> upc_q == uaddr_t'($past(upc_q) + 1'b1));

    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (w.seq_wait && !mfc) |=> $stable(upc_q));

    assert_finish_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (w.seq_end && mfc) |=> upc_q == '0);

    assert_dispatch_leaves_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (upc_q == uaddr_t'(FETCH_LAST)) |=> upc_q > uaddr_t'(FETCH_LAST));

    assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
        (w.seq_if && !w.seq_wait && !w.seq_end && flags[w.fsel])
        |=> upc_q == $past(w.target));
endmodule

// File: tb/test_useq_top.sv
module test_useq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mfc = 1'b0;
    logic [1:0] flags = 2'b00;
    logic [1:0] opcode = 2'b00;
    logic [7:0] ctl_out;
    logic [4:0] upc;
    int checks = 0;
    int failures = 0;

    useq_top i_useq_top (.clk(clk), .rst(rst), .mfc(mfc), .flags(flags),
                         .opcode(opcode), .ctl_out(ctl_out), .upc(upc));

    always #4 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int ue, input int ce);
        checks++;
        if (int'(upc) != ue || int'(ctl_out) != ce) begin
            failures++;
            $display("FAIL %s upc=%0d ctl=%02h expected upc=%0d ctl=%02h",
                     tag, upc, ctl_out, ue, ce);
        end
    endtask

    // runs fetch: arrives at step 2 with the given opcode applied
    task automatic fetch(input logic [1:0] op, input int waits);
        chk("R2 fetch step0", 0, 8'h07);
        tick();
        chk("R3 fetch step1", 1, 8'h08);
        for (int i = 0; i < waits; i++) begin
            tick();
            chk("R4 fetch hold", 1, 8'h08);
        end
        mfc = 1'b1;
        tick();
        mfc = 1'b0;
        opcode = op;
        chk("R4 fetch released", 2, 8'h10);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk("R1 reset state", 0, 8'h07);
    endtask

    task automatic t_op0();
        fetch(2'd0, 2);
        tick();
        chk("R6 dispatch op0", 3, 8'h21);
        tick();
        chk("R5 finish to zero", 0, 8'h07);
    endtask

    task automatic t_op1();
        fetch(2'd1, 0);
        tick();
        chk("R6 dispatch op1", 6, 8'h42);
        tick();
        chk("R4 hold at 6", 6, 8'h42);
        mfc = 1'b1;
        tick();
        mfc = 1'b0;
        chk("R4 advance at 6", 7, 8'h84);
        tick();
        chk("R8 finish held", 7, 8'h84);
        tick();
        chk("R8 finish held", 7, 8'h84);
        mfc = 1'b1;
        tick();
        mfc = 1'b0;
        chk("R8 finish on completion", 0, 8'h07);
    endtask

    task automatic t_op2(input logic [1:0] f, input int ue, input int ce);
        fetch(2'd2, 1);
        flags = f;
        tick();
        chk("R6 dispatch op2", 9, 8'h11);
        tick();
        chk("R7 branch flag0", ue, ce);
        flags = 2'b00;
        tick();
        chk("R5 finish after branch", 0, 8'h07);
    endtask

    task automatic t_op3(input logic [1:0] f, input int ue, input int ce);
        fetch(2'd3, 0);
        flags = f;
        tick();
        chk("R6 dispatch op3", 13, 8'h88);
        tick();
        chk("R7 branch flag1", ue, ce);
        flags = 2'b00;
        tick();
        chk("R5 finish after branch", 0, 8'h07);
    endtask

    task automatic t_opcode_window();
        opcode = 2'd3;
        mfc = 1'b1;                 // no wait bit at step 0: mfc has no effect
        tick();
        mfc = 1'b0;
        chk("R4 mfc ignored", 1, 8'h08);
        mfc = 1'b1;
        tick();
        mfc = 1'b0;
        opcode = 2'd0;              // only the value at step 2 counts
        chk("R6 at step2", 2, 8'h10);
        tick();
        opcode = 2'd2;
        chk("R6 opcode sampled at step2", 3, 8'h21);
        tick();
        chk("R5 finish", 0, 8'h07);
    endtask

    task automatic t_mid_reset();
        fetch(2'd3, 0);
        tick();
        chk("R6 dispatch op3", 13, 8'h88);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset mid routine", 0, 8'h07);
    endtask

    initial begin
        tick();
        t_reset();
        t_op0();
        t_op1();
        t_op2(2'b01, 12, 8'h44);
        t_op2(2'b00, 10, 8'h22);
        t_op2(2'b10, 10, 8'h22);
        t_op3(2'b10, 15, 8'h0C);
        t_op3(2'b01, 14, 8'h03);
        t_opcode_window();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule